// File: doc/BRIEF.md
# Seconds Counter with Match Alarm

A memory-mapped real-time clock for a 32-bit register bus. It keeps a 32-bit seconds count. A prescaler steps the count once every `CLK_HZ` cycles of the core clock. Software can write a new count, which also restarts the prescaler, and can program a compare value. When the count comes to equal the compare value, a raw status flag is set. That flag, gated by a one-bit enable, drives a single level interrupt line. Any write to the acknowledge register drops the flag.

The bus gives each access a one-cycle read or write strobe with a byte address. The low two address bits are ignored. Read data is registered and is valid in the cycle after the read strobe. The top 32 bytes of the address window return eight identification bytes, one per word. The control word always reads as enabled, because the counter cannot be stopped.

Top module: `rtc_match_timer`

## Requirements
- R1: A synchronous active-high `rst` clears the count, compare value, load register, interrupt enable, raw flag, interrupt output and prescaler. After reset, every register reads 0 and `irq` is low.
- R2: The count rises by exactly one every `CLK_HZ` clock cycles and wraps from 0xFFFFFFFF to 0. A read of offset 0x00 returns the count as it stood at the read strobe, on `bus_rdata` in the next cycle.
- R3: A write to offset 0x08 replaces the count with the written value and restarts the prescaler. The count holds that value for `CLK_HZ` cycles, and the first increment lands on the `CLK_HZ`-th rising edge after the write edge.
- R4: A read of offset 0x08 returns the last value written there, not the live count.
- R5: A write to offset 0x04 stores a 32-bit compare value, which reads back from 0x04. If the written value equals the current count, the raw flag is set on that same write edge.
- R6: The raw flag is also set when a load or a seconds step makes the count equal to the compare value, including the step from 0xFFFFFFFF to 0. Once set, the flag stays set until it is cleared. It is not set again while the count merely stays equal.
- R7: Offset 0x10 holds only the interrupt enable, taken from bit 0 of the written data. It reads back as 0 or 1, and all other written bits are discarded.
- R8: The raw flag reads as bit 0 of offset 0x14, and offset 0x18 reads raw AND enable. `irq` equals raw AND enable, and it changes on the same edge as the write that changes either of them.
- R9: Any write to offset 0x1C clears the raw flag, whatever the data. If a seconds step that matches falls on the same edge, the flag stays set.
- R10: Offset 0x0C always reads 1, and writes to it change nothing.
- R11: Offsets 0xFE0, 0xFE4 … 0xFFC return, in the low byte, 0x31, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1 respectively. Byte index = (offset − 0xFE0) >> 2.
- R12: Writes to offsets 0x00, 0x14 and 0x18 have no effect, and a read of 0x1C returns 0. Any unmapped offset reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address within the window |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_rd | input | 1 | One-cycle read strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data, valid the cycle after `bus_rd` |
| irq | output | 1 | Level interrupt, raw flag AND enable |

## Verification
The bench reads the count one cycle before and two cycles after the first step following a load. A prescaler that is not restarted on a load, or that is off by one, returns the wrong value at one of those reads. It programs a compare value equal to the current count, and then one second ahead, and then across the wrap to zero. A design that compared only on seconds steps, or compared with a magnitude test, would miss one of those alarms. After an acknowledge while the count still equals the compare value, the flag is read again: a plain level comparator would set the flag again. Writes of zero data to the acknowledge register and to both status offsets then show whether only the acknowledge register clears the flag, and whether a bit-0-only clear was wrongly built.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  // word indexes (byte offset >> 2) of the decoded registers
  localparam int W_DATA  = 0;
  localparam int W_MATCH = 1;
  localparam int W_LOAD  = 2;
  localparam int W_CTRL  = 3;
  localparam int W_MASK  = 4;
  localparam int W_RAW   = 5;
  localparam int W_MIS   = 6;
  localparam int W_CLR   = 7;

  // identification byte at word index idx of the top 32-byte region
  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd0:    id_byte = 8'h31;
      3'd1:    id_byte = 8'h10;
      3'd2:    id_byte = 8'h14;
      3'd3:    id_byte = 8'h00;
      3'd4:    id_byte = 8'h0D;
      3'd5:    id_byte = 8'hF0;
      3'd6:    id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int CLK_HZ = 50_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic restart_i,
  output logic tick_o
);
  localparam int CNT_W = (CLK_HZ > 1) ? $clog2(CLK_HZ) : 1;
  localparam logic [CNT_W-1:0] TOP = CNT_W'(CLK_HZ - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || restart_i)  cnt_q <= '0;
    else if (cnt_q == TOP) cnt_q <= '0;
    else                   cnt_q <= cnt_q + CNT_W'(1);
  end

  assign tick_o = (cnt_q == TOP);

  // R3
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    restart_i |=> (cnt_q == '0));

  // R2
  tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o);
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_val_i,
  output logic [DATA_W-1:0] count_o,
  output logic [DATA_W-1:0] count_next_o
);
  logic [DATA_W-1:0] count_q;

  always_comb begin
    if (load_i)      count_next_o = load_val_i;
    else if (tick_i) count_next_o = count_q + DATA_W'(1);
    else             count_next_o = count_q;
  end

  always_ff @(posedge clk) begin
    if (rst) count_q <= '0;
    else     count_q <= count_next_o;
  end

  assign count_o = count_q;

  // R3
  load_value_chk: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (count_q == $past(load_val_i)));

  // R2
  step_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !load_i) |=> (count_q == $past(count_q) + DATA_W'(1)));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !load_i) |=> $stable(count_q));
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              match_wr_i,
  input  logic              mask_wr_i,
  input  logic              clear_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              count_event_i,
  input  logic [DATA_W-1:0] count_next_i,
  output logic [DATA_W-1:0] match_o,
  output logic              raw_o,
  output logic              mask_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] match_q, match_next;
  logic raw_q, raw_next, mask_q, mask_next, irq_q, hit;

  always_comb begin
    match_next = match_wr_i ? wdata_i : match_q;
    mask_next  = mask_wr_i ? wdata_i[0] : mask_q;
    // compare only when the count or the compare value has just been updated
    hit        = (match_wr_i || count_event_i) && (count_next_i == match_next);
    if (hit)          raw_next = 1'b1;
    else if (clear_i) raw_next = 1'b0;
    else              raw_next = raw_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      match_q <= '0;
      raw_q   <= 1'b0;
      mask_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      match_q <= match_next;
      raw_q   <= raw_next;
      mask_q  <= mask_next;
      irq_q   <= raw_next & mask_next;
    end
  end

  assign match_o = match_q;
  assign raw_o   = raw_q;
  assign mask_o  = mask_q;
  assign irq_o   = irq_q;

  // R9
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clear_i && !count_event_i && !match_wr_i) |=> !raw_q);

  // R6
  raw_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (raw_q && !clear_i) |=> raw_q);

  // R7
  mask_bit_chk: assert property (@(posedge clk) disable iff (rst)
    mask_wr_i |=> (mask_q == $past(wdata_i[0])));

  // R8
  irq_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o == (raw_q & mask_q));
endmodule

// File: rtl/rtc_regs.sv
module rtc_regs
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] count_i,
  input  logic [DATA_W-1:0] match_i,
  input  logic              raw_i,
  input  logic              mask_i,
  output logic              load_wr_o,
  output logic              match_wr_o,
  output logic              mask_wr_o,
  output logic              clear_wr_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic              id_hit;
  logic [DATA_W-1:0] load_q, rd_mux, rdata_q;
  logic [1:0]        unused_byte_sel;

  assign word            = addr_i[ADDR_W-1:2];
  assign unused_byte_sel = addr_i[1:0];
  assign id_hit          = &addr_i[ADDR_W-1:5];

  assign load_wr_o  = wr_i && !id_hit && (word == WORD_W'(W_LOAD));
  assign match_wr_o = wr_i && !id_hit && (word == WORD_W'(W_MATCH));
  assign mask_wr_o  = wr_i && !id_hit && (word == WORD_W'(W_MASK));
  assign clear_wr_o = wr_i && !id_hit && (word == WORD_W'(W_CLR));

  always_comb begin
    rd_mux = '0;
    if (id_hit) begin
      rd_mux = DATA_W'(id_byte(addr_i[4:2]));
    end else begin
      case (word)
        WORD_W'(W_DATA):  rd_mux = count_i;
        WORD_W'(W_MATCH): rd_mux = match_i;
        WORD_W'(W_LOAD):  rd_mux = load_q;
        WORD_W'(W_CTRL):  rd_mux = DATA_W'(1);
        WORD_W'(W_MASK):  rd_mux = DATA_W'(mask_i);
        WORD_W'(W_RAW):   rd_mux = DATA_W'(raw_i);
        WORD_W'(W_MIS):   rd_mux = DATA_W'(raw_i & mask_i);
        default:          rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      load_q  <= '0;
      rdata_q <= '0;
    end else begin
      if (load_wr_o) load_q  <= wdata_i;
      if (rd_i)      rdata_q <= rd_mux;
    end
  end

  assign rdata_o = rdata_q;

  // R10
  ctrl_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_i && !id_hit && word == WORD_W'(W_CTRL)) |=> (rdata_o == DATA_W'(1)));

  // R12
  clr_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_i && !id_hit && word == WORD_W'(W_CLR)) |=> (rdata_o == '0));

  // R4
  load_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !load_wr_o |=> $stable(load_q));
endmodule

// File: rtl/rtc_match_timer.sv
module rtc_match_timer #(
  parameter int CLK_HZ = 50_000_000,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic              tick, load_wr, match_wr, mask_wr, clear_wr, raw, mask;
  logic [DATA_W-1:0] count, count_next, match;

  rtc_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) regs_i (
    .clk(clk), .rst(rst), .addr_i(bus_addr), .wr_i(bus_wr), .rd_i(bus_rd),
    .wdata_i(bus_wdata), .count_i(count), .match_i(match), .raw_i(raw),
    .mask_i(mask), .load_wr_o(load_wr), .match_wr_o(match_wr),
    .mask_wr_o(mask_wr), .clear_wr_o(clear_wr), .rdata_o(bus_rdata)
  );

  rtc_prescaler #(.CLK_HZ(CLK_HZ)) pre_i (
    .clk(clk), .rst(rst), .restart_i(load_wr), .tick_o(tick)
  );

  rtc_counter #(.DATA_W(DATA_W)) cnt_i (
    .clk(clk), .rst(rst), .tick_i(tick), .load_i(load_wr),
    .load_val_i(bus_wdata), .count_o(count), .count_next_o(count_next)
  );

  rtc_alarm #(.DATA_W(DATA_W)) alarm_i (
    .clk(clk), .rst(rst), .match_wr_i(match_wr), .mask_wr_i(mask_wr),
    .clear_i(clear_wr), .wdata_i(bus_wdata), .count_event_i(load_wr | tick),
    .count_next_i(count_next), .match_o(match), .raw_o(raw),
    .mask_o(mask), .irq_o(irq)
  );

  // R5
  raw_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(raw) |-> (count == match));
endmodule

// File: tb/rtc_match_timer_tb_top.sv
module rtc_match_timer_tb_top;
  localparam int TB_HZ = 64;
  localparam int NV    = 28;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  rtc_match_timer #(.CLK_HZ(TB_HZ), .ADDR_W(12), .DATA_W(32)) dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  typedef struct packed {
    logic        is_wr;
    logic [11:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{1'b1, 12'h004, 32'hDEAD0000, 32'h0,        4'd5},  // R5
    '{1'b0, 12'h004, 32'h0,        32'hDEAD0000, 4'd5},  // R5
    '{1'b1, 12'h008, 32'h12345678, 32'h0,        4'd3},  // R3
    '{1'b0, 12'h008, 32'h0,        32'h12345678, 4'd4},  // R4
    '{1'b0, 12'h000, 32'h0,        32'h12345678, 4'd3},  // R3
    '{1'b1, 12'h00C, 32'h0,        32'h0,        4'd10}, // R10
    '{1'b0, 12'h00C, 32'h0,        32'h1,        4'd10}, // R10
    '{1'b1, 12'h010, 32'hFFFFFFFE, 32'h0,        4'd7},  // R7
    '{1'b0, 12'h010, 32'h0,        32'h0,        4'd7},  // R7
    '{1'b1, 12'h010, 32'hFFFFFFFF, 32'h0,        4'd7},  // R7
    '{1'b0, 12'h010, 32'h0,        32'h1,        4'd7},  // R7
    '{1'b0, 12'h014, 32'h0,        32'h0,        4'd8},  // R8
    '{1'b1, 12'h000, 32'h0,        32'h0,        4'd12}, // R12
    '{1'b0, 12'h000, 32'h0,        32'h12345678, 4'd12}, // R12
    '{1'b1, 12'h010, 32'h0,        32'h0,        4'd7},  // R7
    '{1'b0, 12'h01C, 32'h0,        32'h0,        4'd12}, // R12
    '{1'b1, 12'h020, 32'h55,       32'h0,        4'd12}, // R12
    '{1'b0, 12'h020, 32'h0,        32'h0,        4'd12}, // R12
    '{1'b0, 12'h004, 32'h0,        32'hDEAD0000, 4'd12}, // R12
    '{1'b0, 12'hFE0, 32'h0,        32'h31,       4'd11}, // R11
    '{1'b0, 12'hFE4, 32'h0,        32'h10,       4'd11}, // R11
    '{1'b0, 12'hFE8, 32'h0,        32'h14,       4'd11}, // R11
    '{1'b0, 12'hFEC, 32'h0,        32'h00,       4'd11}, // R11
    '{1'b0, 12'hFF0, 32'h0,        32'h0D,       4'd11}, // R11
    '{1'b0, 12'hFF4, 32'h0,        32'hF0,       4'd11}, // R11
    '{1'b0, 12'hFF8, 32'h0,        32'h05,       4'd11}, // R11
    '{1'b0, 12'hFFC, 32'h0,        32'hB1,       4'd11}, // R11
    '{1'b0, 12'h7FC, 32'h0,        32'h0,        4'd12}  // R12
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rdchk(input logic [11:0] a, input logic [31:0] exp, input string req);
    logic [31:0] v;
    rd(a, v);
    chk(v, exp, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk({31'b0, irq}, 32'h0, "R1");
    rdchk(12'h000, 32'h0, "R1");
    rdchk(12'h004, 32'h0, "R1");
    rdchk(12'h008, 32'h0, "R1");
    rdchk(12'h010, 32'h0, "R1");
    rdchk(12'h014, 32'h0, "R1");

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].is_wr) begin
        wr(VEC[i].addr, VEC[i].data);
      end else begin
        logic [31:0] v;
        rd(VEC[i].addr, v);
        checks++;
        if (v !== VEC[i].exp) begin
          errors++;
          $display("FAIL R%0d vector %0d actual %h expected %h", VEC[i].req, i, v, VEC[i].exp);
        end
      end
    end

    // R3 / R2: a full second after a load, then steady stepping
    wr(12'h008, 32'd100);
    repeat (TB_HZ - 2) @(negedge clk);
    rdchk(12'h000, 32'd100, "R3");
    @(negedge clk);
    rdchk(12'h000, 32'd101, "R3");
    repeat (TB_HZ * 3) @(negedge clk);
    rdchk(12'h000, 32'd104, "R2");

    // R5 immediate match, R8 masking, R12 status writes, R9/R6 clear
    wr(12'h010, 32'h0);
    wr(12'h01C, 32'h0);
    wr(12'h008, 32'd500);
    wr(12'h004, 32'd500);
    rdchk(12'h014, 32'h1, "R5");
    chk({31'b0, irq}, 32'h0, "R8");
    rdchk(12'h018, 32'h0, "R8");
    wr(12'h010, 32'h1);
    chk({31'b0, irq}, 32'h1, "R8");
    rdchk(12'h018, 32'h1, "R8");
    wr(12'h014, 32'h0);
    rdchk(12'h014, 32'h1, "R12");
    wr(12'h018, 32'h0);
    rdchk(12'h014, 32'h1, "R12");
    wr(12'h01C, 32'hFFFFFFFE);
    chk({31'b0, irq}, 32'h0, "R9");
    rdchk(12'h014, 32'h0, "R6");

    // R6 match one second ahead
    wr(12'h008, 32'd1000);
    wr(12'h004, 32'd1001);
    rdchk(12'h014, 32'h0, "R6");
    repeat (TB_HZ) @(negedge clk);
    rdchk(12'h014, 32'h1, "R6");
    chk({31'b0, irq}, 32'h1, "R8");

    // R6 match across the wrap
    wr(12'h01C, 32'h0);
    wr(12'h008, 32'hFFFFFFFF);
    wr(12'h004, 32'h0);
    rdchk(12'h014, 32'h0, "R6");
    repeat (TB_HZ) @(negedge clk);
    rdchk(12'h000, 32'h0, "R2");
    rdchk(12'h014, 32'h1, "R6");

    // R6 load that lands on the compare value
    wr(12'h01C, 32'h0);
    wr(12'h004, 32'd7777);
    rdchk(12'h014, 32'h0, "R6");
    wr(12'h008, 32'd7777);
    rdchk(12'h014, 32'h1, "R6");

    // R8 enable toggles the line directly
    wr(12'h010, 32'h0);
    chk({31'b0, irq}, 32'h0, "R8");
    wr(12'h010, 32'h1);
    chk({31'b0, irq}, 32'h1, "R8");

    // R1 reset in mid-run
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk({31'b0, irq}, 32'h0, "R1");
    rdchk(12'h000, 32'h0, "R1");
    rdchk(12'h004, 32'h0, "R1");
    rdchk(12'h008, 32'h0, "R1");
    rdchk(12'h010, 32'h0, "R1");
    rdchk(12'h014, 32'h0, "R1");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule